// File: doc/BRIEF.md
# Receive Queue with Threshold and Parity Status

This block sits between a serial receiver and a processor's register interface. Each byte the receiver delivers is stored with its parity-error bit in a sixteen-entry first-in first-out queue. The processor and a DMA engine both read from the head of the queue. Two status bits describe the queue. A threshold flag reports that enough bytes have arrived to be worth servicing. A parity flag describes the byte that will be handed out next.

The threshold flag is kept by a three-state machine. In `THR_CLEAR` the flag is 0. A stored byte that brings the fill count to the selected level moves it to `THR_PENDING`, where the flag is 1. A status-register read while pending moves it to `THR_ACKED`, where the flag is also 1. There are two ways back to `THR_CLEAR`:

- Software writes a 0 to the flag bit while in `THR_ACKED` and the count is already below the level.
- A DMA read brings the count below the level from either set state.

A new byte that reaches the level in the same cycle as a software clear goes to `THR_PENDING` instead. The DMA clear takes priority over acknowledgement in `THR_PENDING`. A manual reset or power-on reset returns to `THR_CLEAR` and empties the queue.

Top module: `uart_rx_fifo_flags`

## Requirements
- R1: Accepted bytes leave in arrival order. `head_data` shows the oldest stored byte. `fill_count` rises by one per stored byte and falls by one per read of a non-empty queue. `cpu_rd` and `dma_rd` in the same cycle remove one entry.
- R2: A write while `fill_count` is 16 is dropped. `fill_count` stays 16, and `overrun` is 1 for exactly the one cycle after the dropping edge.
- R3: A read of an empty queue leaves `fill_count` at 0 and `head_data` at the last byte that was read out.
- R4: `thr_flag` goes to 1 on the edge where a stored byte makes `fill_count` greater than or equal to the level. The level is set by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R5: `thr_flag` clears after a `stat_rd` that saw it at 1, followed by a `stat_wr` with `stat_wbit`=0 while `fill_count` is below the level.
- R6: Three kinds of `stat_wr` leave `thr_flag` unchanged: `stat_wbit`=1; `stat_wbit`=0 without an earlier `stat_rd` since the flag was set; `stat_wbit`=0 while `fill_count` is at or above the level.
- R7: A `dma_rd` that leaves `fill_count` below the level clears `thr_flag` without any status write.
- R8: `cpu_rd` alone never clears `thr_flag`, even when it takes the count below the level.
- R9: `perr_flag` equals the parity bit of the head entry when `async_mode`=1 and the queue is not empty. Otherwise it is 0.
- R10: `rst_n`=0, and `soft_rst`=1 at a clock edge, each empty the queue and force both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Manual reset, synchronous |
| wr_en | input | 1 | Store strobe from the receiver |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error seen on this byte |
| cpu_rd | input | 1 | Processor read of the head byte |
| dma_rd | input | 1 | DMA read of the head byte |
| stat_rd | input | 1 | Status register read |
| stat_wr | input | 1 | Status register write |
| stat_wbit | input | 1 | Value written to the threshold bit |
| trig_sel | input | 2 | Threshold level select |
| async_mode | input | 1 | 1 enables the parity indication |
| head_data | output | 8 | Byte at the head of the queue |
| fill_count | output | 5 | Number of stored bytes |
| thr_flag | output | 1 | Threshold flag |
| perr_flag | output | 1 | Parity flag of the head entry |
| overrun | output | 1 | One-cycle pulse for a dropped byte |

## Verification
The checker assumes that every input is at a known level after reset. It also assumes that `trig_sel` and `async_mode` change only while no flag decision is in progress, since the clearing properties work out the level from the current `trig_sel`. The stimulus performs one operation per clock: a store, a read, a status access or a reset. It changes `trig_sel` and `async_mode` only between operations, with no read pending. Each antecedent that mixes strobes therefore excludes the others explicitly, and the bench never puts two strobes in one cycle, so the clearing properties see one cause at a time.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int LVL_W = 5;

    typedef enum logic [1:0] {
        THR_CLEAR   = 2'd0,
        THR_PENDING = 2'd1,
        THR_ACKED   = 2'd2
    } thr_state_t;

    function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
        logic [LVL_W-1:0] lvl;
        unique case (sel)
            2'd0: lvl = LVL_W'(1);
            2'd1: lvl = LVL_W'(4);
            2'd2: lvl = LVL_W'(8);
            default: lvl = LVL_W'(14);
        endcase
        return lvl;
    endfunction
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
    parameter int DEPTH = 16,
    parameter int DW    = 9,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [DW-1:0] last_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            last_q <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = (count != '0) ? mem[rd_ptr] : last_q;
endmodule

// File: rtl/rxq_thr_fsm.sv
module rxq_thr_fsm
    import rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_ok,
    input  logic          dma_pop,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic          stat_wbit,
    input  logic [CW-1:0] cnt_now,
    input  logic [CW-1:0] cnt_next,
    input  logic [CW-1:0] level,
    output logic          flag
);
    thr_state_t state_q, state_d;
    logic reach, dma_drop, sw_clear;

    assign reach    = push_ok && (cnt_next >= level);
    assign dma_drop = dma_pop && (cnt_next < level);
    assign sw_clear = stat_wr && !stat_wbit && (cnt_now < level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= THR_CLEAR;
        else if (clr) state_q <= THR_CLEAR;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_CLEAR: begin
                if (reach) state_d = THR_PENDING;
            end
            THR_PENDING: begin
                if (dma_drop)     state_d = THR_CLEAR;
                else if (stat_rd) state_d = THR_ACKED;
            end
            THR_ACKED: begin
                if (dma_drop)      state_d = THR_CLEAR;
                else if (sw_clear) state_d = reach ? THR_PENDING : THR_CLEAR;
            end
            default: state_d = THR_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            THR_PENDING, THR_ACKED: flag = 1'b1;
            default:                flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_fifo_flags.sv
module uart_rx_fifo_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_perr,
    input  logic          cpu_rd,
    input  logic          dma_rd,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic          stat_wbit,
    input  logic [1:0]    trig_sel,
    input  logic          async_mode,
    output logic [7:0]    head_data,
    output logic [CW-1:0] fill_count,
    output logic          thr_flag,
    output logic          perr_flag,
    output logic          overrun
);
    logic          nonempty, full, push_ok, pop_ok, dma_pop;
    logic [CW-1:0] cnt_next, level;
    logic [8:0]    head_entry;

    assign nonempty = (fill_count != '0);
    assign full     = (fill_count == CW'(DEPTH));
    assign push_ok  = wr_en && !full;
    assign pop_ok   = (cpu_rd || dma_rd) && nonempty;
    assign dma_pop  = dma_rd && nonempty;
    assign cnt_next = fill_count + CW'(push_ok) - CW'(pop_ok);
    assign level    = CW'(trig_level(trig_sel));

    rxq_storage #(.DEPTH(DEPTH), .DW(9)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .push  (push_ok),
        .pop   (pop_ok),
        .din   ({wr_perr, wr_data}),
        .dout  (head_entry),
        .count (fill_count)
    );

    rxq_thr_fsm #(.CW(CW)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .push_ok   (push_ok),
        .dma_pop   (dma_pop),
        .stat_rd   (stat_rd),
        .stat_wr   (stat_wr),
        .stat_wbit (stat_wbit),
        .cnt_now   (fill_count),
        .cnt_next  (cnt_next),
        .level     (level),
        .flag      (thr_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= wr_en && full && !soft_rst;
    end

    assign head_data = head_entry[7:0];
    assign perr_flag = async_mode && nonempty && head_entry[8];
endmodule

// File: rtl/rxq_flags_checker.sv
module rxq_flags_checker
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic          wr_perr,
    input logic          cpu_rd,
    input logic          dma_rd,
    input logic          stat_rd,
    input logic          stat_wr,
    input logic          stat_wbit,
    input logic [1:0]    trig_sel,
    input logic          async_mode,
    input logic [7:0]    head_data,
    input logic [CW-1:0] fill_count,
    input logic          thr_flag,
    input logic          perr_flag,
    input logic          overrun
);
    logic [CW-1:0] lvl;
    logic          unused_ok;
    assign lvl       = CW'(trig_level(trig_sel));
    assign unused_ok = ^{wr_data, wr_perr, stat_rd};

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    assert_drop_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_count == CW'(DEPTH) && !cpu_rd && !dma_rd && !soft_rst)
        |=> (overrun && fill_count == CW'(DEPTH)));

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && !wr_en && (cpu_rd || dma_rd) && !soft_rst)
        |=> (fill_count == '0 && $stable(head_data)));

    assert_set_by_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_flag) |-> $past(wr_en));

    assert_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thr_flag) |-> $past((stat_wr && !stat_wbit) || dma_rd || soft_rst));

    assert_write_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag && stat_wr && stat_wbit && !dma_rd && !soft_rst) |=> thr_flag);

    assert_dma_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag && dma_rd && !cpu_rd && !wr_en && !soft_rst && fill_count != '0
         && (fill_count - CW'(1)) < lvl) |=> !thr_flag);

    assert_cpu_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag && cpu_rd && !dma_rd && !stat_wr && !soft_rst) |=> thr_flag);

    assert_perr_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode || fill_count == '0) |-> !perr_flag);

    assert_manual_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!thr_flag && !perr_flag && fill_count == '0));
endmodule

bind uart_rx_fifo_flags rxq_flags_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_rx_fifo_flags_test.sv
module uart_rx_fifo_flags_test;
    localparam int CLK_PERIOD = 10;
    // op codes: 0 store, 1 cpu read, 2 dma read, 3 status read,
    // 4 write 0, 5 write 1, 6 idle, 7 manual reset
    // vector: {op[3], data[8], perr, exp_cnt[5], exp_thr, exp_perr, exp_head[8]}
    localparam int NV = 15;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 8'hA5, 1'b0, 5'd1, 1'b0, 1'b0, 8'hA5},
        {3'd0, 8'h3C, 1'b1, 5'd2, 1'b0, 1'b0, 8'hA5},
        {3'd0, 8'h11, 1'b0, 5'd3, 1'b0, 1'b0, 8'hA5},
        {3'd0, 8'h22, 1'b0, 5'd4, 1'b1, 1'b0, 8'hA5},
        {3'd4, 8'h00, 1'b0, 5'd4, 1'b1, 1'b0, 8'hA5},
        {3'd3, 8'h00, 1'b0, 5'd4, 1'b1, 1'b0, 8'hA5},
        {3'd4, 8'h00, 1'b0, 5'd4, 1'b1, 1'b0, 8'hA5},
        {3'd1, 8'h00, 1'b0, 5'd3, 1'b1, 1'b1, 8'h3C},
        {3'd5, 8'h00, 1'b0, 5'd3, 1'b1, 1'b1, 8'h3C},
        {3'd4, 8'h00, 1'b0, 5'd3, 1'b0, 1'b1, 8'h3C},
        {3'd1, 8'h00, 1'b0, 5'd2, 1'b0, 1'b0, 8'h11},
        {3'd0, 8'h44, 1'b1, 5'd3, 1'b0, 1'b0, 8'h11},
        {3'd0, 8'h55, 1'b0, 5'd4, 1'b1, 1'b0, 8'h11},
        {3'd2, 8'h00, 1'b0, 5'd3, 1'b0, 1'b0, 8'h22},
        {3'd2, 8'h00, 1'b0, 5'd2, 1'b0, 1'b1, 8'h44}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, wr_en = 1'b0, wr_perr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cpu_rd = 1'b0, dma_rd = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0, stat_wbit = 1'b0;
    logic [1:0] trig_sel = 2'd1;
    logic       async_mode = 1'b1;
    logic [7:0] head_data;
    logic [4:0] fill_count;
    logic       thr_flag, perr_flag, overrun;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_fifo_flags uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] code, input logic [7:0] d, input logic p);
        wr_en    = (code == 3'd0);
        wr_data  = d;
        wr_perr  = p;
        cpu_rd   = (code == 3'd1);
        dma_rd   = (code == 3'd2);
        stat_rd  = (code == 3'd3);
        stat_wr  = (code == 3'd4) || (code == 3'd5);
        stat_wbit = (code == 3'd5);
        soft_rst = (code == 3'd7);
        @(posedge clk);
        #1;
        {wr_en, cpu_rd, dma_rd, stat_rd, stat_wr, stat_wbit, soft_rst} = '0;
    endtask

    function automatic int lvl_of(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: power-on reset state
        chk("R10 reset count", fill_count, 0);
        chk("R10 reset thr", thr_flag, 0);
        chk("R10 reset perr", perr_flag, 0);
        chk("R2 reset overrun", overrun, 0);

        // table walk, trigger level 4 (R1 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][26:24], VEC[i][23:16], VEC[i][15]);
            chk($sformatf("R1 vec%0d count", i), fill_count, VEC[i][14:10]);
            chk($sformatf("R5/R6/R7/R8 vec%0d thr", i), thr_flag, VEC[i][9]);
            chk($sformatf("R9 vec%0d perr", i), perr_flag, VEC[i][8]);
            chk($sformatf("R1 vec%0d head", i), head_data, VEC[i][7:0]);
        end

        // R4: every trigger encoding
        for (int s = 0; s < 4; s++) begin
            op(3'd7, 8'h00, 1'b0);
            trig_sel = 2'(s);
            for (int k = 0; k < lvl_of(s) - 1; k++) op(3'd0, 8'(k), 1'b0);
            chk($sformatf("R4 sel%0d below", s), thr_flag, 0);
            op(3'd0, 8'hEE, 1'b0);
            chk($sformatf("R4 sel%0d reached", s), thr_flag, 1);
        end

        // R2: full queue drops and pulses overrun
        op(3'd7, 8'h00, 1'b0);
        trig_sel = 2'd3;
        for (int k = 0; k < 16; k++) op(3'd0, 8'(k + 16), 1'b0);
        chk("R2 full count", fill_count, 16);
        op(3'd0, 8'hFF, 1'b1);
        chk("R2 drop count", fill_count, 16);
        chk("R2 overrun pulse", overrun, 1);
        op(3'd6, 8'h00, 1'b0);
        chk("R2 overrun one cycle", overrun, 0);
        // R1 order, R8 cpu drain keeps flag
        for (int k = 0; k < 16; k++) begin
            chk("R1 drain order", head_data, k + 16);
            op(3'd1, 8'h00, 1'b0);
        end
        chk("R8 cpu drain keeps flag", thr_flag, 1);
        // R3: empty reads
        op(3'd1, 8'h00, 1'b0);
        chk("R3 empty cpu count", fill_count, 0);
        chk("R3 empty cpu head", head_data, 31);
        op(3'd2, 8'h00, 1'b0);
        chk("R3 empty dma count", fill_count, 0);
        chk("R3 empty dma head", head_data, 31);

        // R7: DMA clear straight from pending, level 1
        op(3'd7, 8'h00, 1'b0);
        trig_sel = 2'd0;
        op(3'd0, 8'h77, 1'b0);
        chk("R7 set", thr_flag, 1);
        op(3'd2, 8'h00, 1'b0);
        chk("R7 dma clear", thr_flag, 0);

        // R9: parity only in async mode
        op(3'd0, 8'h66, 1'b1);
        async_mode = 1'b0;
        #1;
        chk("R9 sync mode perr", perr_flag, 0);
        async_mode = 1'b1;
        #1;
        chk("R9 async mode perr", perr_flag, 1);

        // R10: manual reset
        chk("R10 before thr", thr_flag, 1);
        op(3'd7, 8'h00, 1'b0);
        chk("R10 manual count", fill_count, 0);
        chk("R10 manual thr", thr_flag, 0);
        chk("R10 manual perr", perr_flag, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule